// File: doc/BRIEF.md
# Auto-Ranging Frequency Counter

This block measures how often a pulse train rises during a fixed gate window timed from the system clock. The default window is one second at 125 MHz. The input is asynchronous. It is brought into the clock domain, and each rising edge feeds a chain of decade dividers. The divider tap is picked by the current measurement range, which divides the edge count by 1, 10, 100 or 1000. A counter collects the divided ticks. At the end of each window the count becomes the displayed reading, which never goes above the count limit (3999 by default).

After each window the block picks the range for the next one, so that the reading stays inside the limit. If the count is too large and a coarser range exists, the block moves up one decade. In that case the display keeps its previous value, because the new count is not valid. If the count is below a low threshold (360 by default) and a finer range exists, the block moves down one decade, and the display does show that count. At the coarsest range, a count that is still too large is shown as overload.

With peak hold on, the display changes only when the new result stands for a higher frequency than the one already shown. The two results are compared after each is scaled by its own range. The displayed range drives decimal-point placement elsewhere in the instrument.

Top module: `freq_autorange`

## Requirements
- R1: `gate_done` is high for exactly one cycle at the end of every window, so consecutive pulses are GATE_CYCLES clock cycles apart. The first pulse comes GATE_CYCLES cycles after reset is released.
- R2: Only rising edges of `sig_in` are counted. Falling edges are not. Each edge passes a two-flop synchroniser before it is counted.
- R3: The count for a window is the number of rising edges in that window divided by 10^r, rounded down, where r is the range in use (0 = ×1, 1 = ×10, 2 = ×100, 3 = ×1000). The divider is cleared at the start of every window. `reading` never exceeds COUNT_LIMIT.
- R4: If the count is above COUNT_LIMIT and r is below RANGES-1, the next window uses r+1. `reading`, `range_sel` and `over_flag` keep their values for that window.
- R5: If the count is at most COUNT_LIMIT but below DOWN_THRESH, and r > 0, the count is displayed and the next window uses r-1.
- R6: If the count is above COUNT_LIMIT at range RANGES-1, the display shows overload: `over_flag` = 1, `reading` = COUNT_LIMIT, `range_sel` = RANGES-1. The next displayed in-limit result clears `over_flag`.
- R7: While `peak_hold` is 1 at the end of a window, the display takes the new result only when count×10^r is greater than the displayed reading×10^range_sel. Overload counts as larger than any in-limit value.
- R8: `reading`, `range_sel` and `over_flag` change only in the cycle in which `gate_done` is 1.
- R9: Reset clears the display to reading 0, range 0, no overload, with `gate_done` low. The first window then measures at range 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the window length is counted in its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_in | input | 1 | Asynchronous pulse train to be measured |
| peak_hold | input | 1 | 1 = keep the highest result seen; 0 = show every valid result |
| reading | output | $clog2(COUNT_LIMIT+2) | Displayed count, 0 to COUNT_LIMIT |
| range_sel | output | $clog2(RANGES) | Decade of the displayed count (0 = ×1) |
| over_flag | output | 1 | Overload: the input is too fast even at the coarsest range |
| gate_done | output | 1 | One-cycle pulse at the end of each window, with the display settled |

## Verification
On every cycle, the checker confirms four things:
- The display changes only on a `gate_done` pulse, and that pulse never lasts longer than one cycle.
- An overload indication always comes with the top range and the limit value.
- The reading stays within the limit.
- With peak hold on, the scaled value shown never decreases.

Some behaviours only the bench scenarios can show, because they depend on how many edges arrived in a window:
- the up-steps that leave the display unchanged;
- the down-steps toward the finest range;
- the exact rounded-down counts;
- the fact that falling edges are ignored.

// File: rtl/freq_autorange_pkg.sv
package freq_autorange_pkg;

    typedef enum logic [1:0] {
        STEP_KEEP = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } range_step_e;

    // Frequency-proportional value of a count at a decade; overload ranks above all.
    function automatic logic [63:0] far_scale(logic [31:0] cnt, int dec, logic ovl);
        logic [63:0] m;
        m = 64'(cnt);
        for (int i = 0; i < 8; i++) begin
            if (i < dec) m = m * 64'd10;
        end
        if (ovl) m = '1;
        return m;
    endfunction

endpackage

// File: rtl/far_sync_edge.sv
module far_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], din};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/far_gate_timer.sv
module far_gate_timer #(
    parameter int GATE_CYCLES = 125_000_000,
    localparam int TW = $clog2(GATE_CYCLES)
) (
    input  logic clk,
    input  logic rst_n,
    output logic gate_end
);
    logic [TW-1:0] tmr_d, tmr_q;

    assign gate_end = (tmr_q == TW'(GATE_CYCLES - 1));

    always_comb begin
        tmr_d = gate_end ? '0 : tmr_q + TW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end
endmodule

// File: rtl/far_decade_chain.sv
module far_decade_chain #(
    parameter int RANGES = 4,
    localparam int RW = $clog2(RANGES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          pulse,
    input  logic [RW-1:0] sel,
    output logic          tick
);
    localparam int NSTG = RANGES - 1;

    logic [3:0]        dig_q [NSTG];
    logic [RANGES-1:0] carry;

    // carry[i] = an edge that has passed i decade stages
    always_comb begin
        logic c;
        c = pulse;
        for (int i = 0; i < RANGES; i++) begin
            carry[i] = c;
            if (i < NSTG) c = c && (dig_q[i] == 4'd9);
        end
    end

    for (genvar g = 0; g < NSTG; g++) begin : g_stage
        logic [3:0] dig_d;
        always_comb begin
            dig_d = dig_q[g];
            if (clr)           dig_d = '0;
            else if (carry[g]) dig_d = (dig_q[g] == 4'd9) ? 4'd0 : dig_q[g] + 4'd1;
        end
        always_ff @(posedge clk) begin
            if (!rst_n) dig_q[g] <= '0;
            else        dig_q[g] <= dig_d;
        end
    end

    always_comb begin
        tick = 1'b0;
        for (int i = 0; i < RANGES; i++) begin
            if (sel == RW'(i)) tick = carry[i];
        end
    end
endmodule

// File: rtl/freq_autorange.sv
module freq_autorange
    import freq_autorange_pkg::*;
#(
    parameter int GATE_CYCLES = 125_000_000,
    parameter int COUNT_LIMIT = 3999,
    parameter int DOWN_THRESH = 360,
    parameter int RANGES      = 4,
    localparam int CW = $clog2(COUNT_LIMIT + 2),
    localparam int RW = $clog2(RANGES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sig_in,
    input  logic          peak_hold,
    output logic [CW-1:0] reading,
    output logic [RW-1:0] range_sel,
    output logic          over_flag,
    output logic          gate_done
);
    localparam logic [CW-1:0] LIM_C = CW'(COUNT_LIMIT);
    localparam logic [CW-1:0] THR_C = CW'(DOWN_THRESH);
    localparam logic [RW-1:0] TOP_R = RW'(RANGES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [RW-1:0] meas;
        logic [CW-1:0] disp;
        logic [RW-1:0] drange;
        logic          ovl;
        logic          done;
    } far_state_t;

    far_state_t st_q, st_d;

    logic gate_end, rise, tick;

    far_sync_edge #(.STAGES(2)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .din (sig_in),
        .rise (rise)
    );

    far_gate_timer #(.GATE_CYCLES(GATE_CYCLES)) u_gate (
        .clk (clk),
        .rst_n (rst_n),
        .gate_end (gate_end)
    );

    far_decade_chain #(.RANGES(RANGES)) u_dec (
        .clk (clk),
        .rst_n (rst_n),
        .clr (gate_end),
        .pulse (rise),
        .sel (st_q.meas),
        .tick (tick)
    );

    logic          inc, too_big, show, new_ovl;
    logic [CW-1:0] final_cnt;
    logic [63:0]   new_mag, held_mag;
    range_step_e   step;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        inc       = tick && (st_q.cnt <= LIM_C);
        final_cnt = inc ? st_q.cnt + CW'(1) : st_q.cnt;
        too_big   = final_cnt > LIM_C;
        show      = 1'b0;
        new_ovl   = 1'b0;
        step      = STEP_KEEP;
        if (inc) st_d.cnt = final_cnt;

        if (gate_end) begin
            st_d.cnt  = '0;
            st_d.done = 1'b1;
            if (too_big && st_q.meas != TOP_R) begin
                step = STEP_UP;
            end else begin
                show    = 1'b1;
                new_ovl = too_big;
                if (!too_big && final_cnt < THR_C && st_q.meas != '0) step = STEP_DOWN;
            end
        end

        new_mag  = far_scale(32'(final_cnt), int'(st_q.meas), new_ovl);
        held_mag = far_scale(32'(st_q.disp), int'(st_q.drange), st_q.ovl);

        if (show && (!peak_hold || new_mag > held_mag)) begin
            st_d.disp   = new_ovl ? LIM_C : final_cnt;
            st_d.drange = st_q.meas;
            st_d.ovl    = new_ovl;
        end

        case (step)
            STEP_UP:   st_d.meas = st_q.meas + RW'(1);
            STEP_DOWN: st_d.meas = st_q.meas - RW'(1);
            default:   st_d.meas = st_q.meas;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reading   = st_q.disp;
    assign range_sel = st_q.drange;
    assign over_flag = st_q.ovl;
    assign gate_done = st_q.done;
endmodule

// File: rtl/freq_autorange_chk.sv
module freq_autorange_chk
    import freq_autorange_pkg::*;
#(
    parameter int COUNT_LIMIT = 3999,
    parameter int RANGES      = 4,
    localparam int CW = $clog2(COUNT_LIMIT + 2),
    localparam int RW = $clog2(RANGES)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          peak_hold,
    input logic [CW-1:0] reading,
    input logic [RW-1:0] range_sel,
    input logic          over_flag,
    input logic          gate_done
);
    a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        gate_done |=> !gate_done);

    a_r8_display_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_done |-> ($stable(reading) && $stable(range_sel) && $stable(over_flag)));

    a_r6_overload_shape: assert property (@(posedge clk) disable iff (!rst_n)
        over_flag |-> (range_sel == RW'(RANGES - 1) && reading == CW'(COUNT_LIMIT)));

    a_r3_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
        reading <= CW'(COUNT_LIMIT));

    a_r7_peak_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_done && $past(peak_hold)) |->
        far_scale(32'(reading), int'(range_sel), over_flag) >=
        far_scale(32'($past(reading)), int'($past(range_sel)), $past(over_flag)));
endmodule

bind freq_autorange freq_autorange_chk #(
    .COUNT_LIMIT(COUNT_LIMIT),
    .RANGES(RANGES)
) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .peak_hold(peak_hold),
    .reading(reading),
    .range_sel(range_sel),
    .over_flag(over_flag),
    .gate_done(gate_done)
);

// File: tb/freq_autorange_test.sv
module freq_autorange_test;
    localparam int GATE = 5000;
    localparam int LIM  = 19;
    localparam int THR  = 2;
    localparam int NR   = 3;

    logic       clk = 1'b0, rst_n = 1'b0, sig = 1'b0, peak = 1'b0;
    logic [4:0] reading;
    logic [1:0] range_sel;
    logic       over_flag, gate_done;

    freq_autorange #(
        .GATE_CYCLES(GATE), .COUNT_LIMIT(LIM), .DOWN_THRESH(THR), .RANGES(NR)
    ) uut (
        .clk(clk), .rst_n(rst_n), .sig_in(sig), .peak_hold(peak),
        .reading(reading), .range_sel(range_sel), .over_flag(over_flag), .gate_done(gate_done)
    );

    always #4 clk = ~clk;

    int  checks = 0, fails = 0;
    bit  finished = 0;
    int  half = 0, gcnt = 0;

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // stimulus: square wave with 'half' cycles per level
    always @(negedge clk) begin
        if (half > 0) begin
            gcnt++;
            if (gcnt >= half) begin
                gcnt = 0;
                sig <= ~sig;
            end
        end
    end

    // behavioural reference
    bit  hist[$] = '{0, 0, 0};
    int  m_pos, m_raw, m_meas, m_disp, m_drange;
    bit  m_over, m_done;

    function automatic longint mag(int c, int r, bit ov);
        return ov ? 64'h7fff_ffff_ffff_ffff : longint'(c) * (10 ** r);
    endfunction

    always @(posedge clk) begin
        int c, cand;
        bit ov;
        if (!rst_n) begin
            hist = '{0, 0, 0};
            m_pos = 0; m_raw = 0; m_meas = 0; m_disp = 0; m_drange = 0;
            m_over = 0; m_done = 0;
        end else begin
            if (hist[1] && !hist[0]) m_raw++;
            void'(hist.pop_front());
            hist.push_back(sig);
            m_done = 0;
            if (m_pos == GATE - 1) begin
                m_pos  = 0;
                m_done = 1;
                c = m_raw / (10 ** m_meas);
                m_raw = 0;
                if (c > LIM && m_meas < NR - 1) begin
                    m_meas++;
                end else begin
                    ov   = (c > LIM);
                    cand = ov ? LIM : c;
                    if (!peak || mag(cand, m_meas, ov) > mag(m_disp, m_drange, m_over)) begin
                        m_disp = cand; m_drange = m_meas; m_over = ov;
                    end
                    if (!ov && c < THR && m_meas > 0) m_meas--;
                end
            end else begin
                m_pos++;
            end
        end
    end

    // compare against the reference on every cycle
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(reading == 5'(m_disp), "R3", "reading", reading, m_disp);
            chk(range_sel == 2'(m_drange), "R4", "range_sel", range_sel, m_drange);
            chk(over_flag == m_over, "R6", "over_flag", over_flag, m_over);
            chk(gate_done == m_done, "R1", "gate_done", gate_done, m_done);
        end
    end

    int gap;
    task automatic wait_gate();
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (!gate_done);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(reading == 0 && range_sel == 0 && over_flag == 0 && gate_done == 0,
            "R9", "reset display", {reading, range_sel, over_flag, gate_done}, 0);
        half  = 2;
        rst_n = 1'b1;

        // period 4: two up-steps, then 12 at x100
        wait_gate();
        chk(gap == GATE, "R1", "first window length", gap, GATE);
        chk(reading == 0 && range_sel == 0, "R4", "display held on up-step", reading, 0);
        wait_gate();
        chk(gap == GATE, "R1", "window spacing", gap, GATE);
        chk(range_sel == 0 && reading == 0, "R4", "display held on second up-step", range_sel, 0);
        wait_gate();
        chk(range_sel == 2, "R4", "range after two steps", range_sel, 2);
        chk(reading == 12, "R3", "count at x100", reading, 12);

        // period 2: overload at top range
        half = 1;
        wait_gate();
        chk(over_flag == 1, "R6", "overload flag", over_flag, 1);
        chk(reading == LIM && range_sel == 2, "R6", "overload reading", reading, LIM);

        // period 8: in-limit result clears overload
        half = 4;
        wait_gate();
        chk(over_flag == 0, "R6", "overload cleared", over_flag, 0);
        chk(reading == 6, "R3", "count at x100", reading, 6);

        // peak hold: lower result ignored, higher accepted
        peak = 1'b1;
        half = 10;
        wait_gate();
        chk(reading == 6 && range_sel == 2, "R7", "lower result ignored", reading, 6);
        half = 3;
        wait_gate();
        chk(reading == 8, "R7", "higher result taken", reading, 8);

        // slow input: down-steps to finest range
        peak = 1'b0;
        half = 250;
        wait_gate();
        chk(reading == 0 && range_sel == 2, "R5", "low count shown before down-step", reading, 0);
        wait_gate();
        chk(range_sel == 1 && reading == 1, "R5", "second down-step", range_sel, 1);
        wait_gate();
        chk(range_sel == 0, "R5", "finest range reached", range_sel, 0);
        chk(reading >= 9 && reading <= 11, "R2", "rising edges only", reading, 10);

        repeat (5) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule